// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out one atomic memory instruction at a time against a single synchronous memory port. A pipeline hands it the instruction's opcode byte, its 32-bit immediate, the base register value, a 16-bit signed displacement, the value of the register that supplies data, and the current contents of the accumulator register R0. The block then checks that the encoding is one it accepts. If it is, the block reads the target location and computes the new value. It writes that value back unless a compare-exchange misses, and it reports at most one register update for the pipeline to retire.

While a read-modify-write is in flight, the block raises a lock output toward the memory system. This keeps any other requester from slipping an access in between the read and the write. Operations come in two widths, 32-bit and 64-bit. In 32-bit mode every value returned to a register is zero-extended. The memory is told the width, and it updates only the low four bytes of the addressed doubleword.

Top module: `rmw_atomic_unit`

## Requirements
- R1: Only opcode bytes 0xC3 (32-bit) and 0xDB (64-bit) are accepted. Any other opcode byte, including the byte and half-word sizes 0xD3 and 0xCB, completes with `illegal` high and issues no memory request.
- R2: The immediate must be zero above bit 7, and bits 7:0 must be one of 0x00, 0x01, 0x40, 0x41, 0x50, 0x51, 0xA0, 0xA1, 0xE1 or 0xF1. Any other immediate completes with `illegal` high, no memory request and no register write-back.
- R3: The memory address is the base value plus the displacement sign-extended to the address width. The read and the write both use that address.
- R4: Immediate bits 7:4 of 0x0, 0x4, 0x5 and 0xA store old+src, old|src, old&src and old^src respectively. In 32-bit mode (`mem_wide` low) the operands and the stored result are the low 32 bits, and the upper 32 bits of the write data are zero.
- R5: Immediate bit 0 set on add, or, and, xor: the old memory value (zero-extended in 32-bit mode) is written back to the source register. With bit 0 clear, no register is written.
- R6: Immediate 0xE1 stores the source value and returns the old memory value to the source register.
- R7: Immediate 0xF1 compares the old memory value with R0, using the low 32 bits only in 32-bit mode. On a match it stores the source value. It always returns the old value, zero-extended, to R0 and never to the source register.
- R8: A compare-exchange that misses performs the read and no write.
- R9: `mem_lock` is high in every cycle that `mem_req` is high, and it stays high from the accepted read until the write completes.
- R10: A request that is not acknowledged by `mem_ready` holds its address, direction and write data unchanged into the next cycle.
- R11: `done` is a one-cycle pulse per accepted operation. A `start` raised while `busy` is high is ignored.
- R12: After reset `busy`, `done`, `mem_req` and `mem_lock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| opcode | input | 8 | Instruction opcode byte |
| imm | input | 32 | Instruction immediate (operation select) |
| base | input | 64 | Base register value |
| offset | input | 16 | Signed displacement |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | Accumulator register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Completion with a rejected encoding |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | Access is 64-bit (else low 32 bits) |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Request acknowledged this cycle |
| mem_lock | output | 1 | Exclusive hold on memory |
| wb_src_en | output | 1 | Write wb_data to the source register |
| wb_r0_en | output | 1 | Write wb_data to R0 |
| wb_data | output | 64 | Old memory value for write-back |

## Verification
The hardest case to reach is a compare-exchange that matches in 32-bit mode while R0's upper half differs from memory. Random R0 values almost never match, so the stimulus builds R0 from the current model contents of the target doubleword in half of the draws, with its upper 32 bits left random. A second hard case is a stray `start` arriving mid-operation. A directed run reaches it by holding `mem_ready` low to freeze the block in its read phase while extra start pulses carry a bogus opcode.

// File: rtl/amo_pkg.sv
// Package: shared types for the atomic read-modify-write sequencer.
// Assumes: nothing beyond the SystemVerilog standard.
package amo_pkg;

    // Operation selected by the immediate.
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_OR   = 3'd1,
        OP_AND  = 3'd2,
        OP_XOR  = 3'd3,
        OP_XCHG = 3'd4,
        OP_CMPX = 3'd5
    } amo_op_e;

    // Sequencer phases.
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_READ  = 3'd1,
        S_COMP  = 3'd2,
        S_WRITE = 3'd3,
        S_WB    = 3'd4
    } amo_state_e;

endpackage

// File: rtl/amo_decode.sv
// Module: amo_decode
// Classifies an opcode byte and immediate into an atomic operation.
// Assumes: combinational use, sampled only in the idle cycle that accepts start.
module amo_decode
    import amo_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input  logic [7:0]       opcode,
    input  logic [IMM_W-1:0] imm,
    output logic             legal,
    output logic             wide,
    output logic             fetch,
    output amo_op_e          op
);

    localparam int IMM_HI = IMM_W - 8;

    logic opc_ok;
    logic imm_ok;

    // Opcode check: store-from-register class, atomic mode, word or doubleword size.
    always_comb begin
        opc_ok = (opcode[2:0] == 3'b011) && (opcode[7:5] == 3'b110) &&
                 ((opcode[4:3] == 2'b00) || (opcode[4:3] == 2'b11));
        wide   = (opcode[4:3] == 2'b11);
    end

    // Immediate check and operation select.
    always_comb begin
        imm_ok = (imm[IMM_W-1:8] == {IMM_HI{1'b0}});
        op     = OP_ADD;
        unique case (imm[7:0])
            8'h00, 8'h01: op = OP_ADD;
            8'h40, 8'h41: op = OP_OR;
            8'h50, 8'h51: op = OP_AND;
            8'hA0, 8'hA1: op = OP_XOR;
            8'hE1:        op = OP_XCHG;
            8'hF1:        op = OP_CMPX;
            default:      imm_ok = 1'b0;
        endcase
        fetch = imm[0];
        legal = opc_ok && imm_ok;
    end

endmodule

// File: rtl/amo_alu.sv
// Module: amo_alu
// Computes the value to store from the old memory value and the operands,
// and says whether a write is needed at all (compare-exchange miss skips it).
// Assumes: old_val is already zero-extended when wide is low.
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amo_op_e           op,
    input  logic              wide,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] new_val,
    output logic              do_write
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] raw;
    logic              hit;

    // Comparison for compare-exchange, at the selected width.
    always_comb begin
        hit = wide ? (old_val == cmp_val)
                   : (old_val[HALF_W-1:0] == cmp_val[HALF_W-1:0]);
    end

    // Operation result, trimmed to the selected width.
    always_comb begin
        unique case (op)
            OP_ADD:  raw = old_val + src_val;
            OP_OR:   raw = old_val | src_val;
            OP_AND:  raw = old_val & src_val;
            OP_XOR:  raw = old_val ^ src_val;
            default: raw = src_val;
        endcase
        new_val  = wide ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
        do_write = !((op == OP_CMPX) && !hit);
    end

endmodule

// File: rtl/amo_ctrl.sv
// Module: amo_ctrl
// Phase sequencer: idle, read, compute, write, write-back.
// Assumes: mem_ready is only meaningful while a request is up; do_write is
// valid during the compute phase.
module amo_ctrl
    import amo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic legal,
    input  logic mem_ready,
    input  logic do_write,
    output logic accept,
    output logic in_read,
    output logic in_comp,
    output logic in_write,
    output logic in_wb,
    output logic busy
);

    amo_state_e state, state_nx;

    // Next-phase selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = legal ? S_READ : S_WB;
            S_READ:  if (mem_ready) state_nx = S_COMP;
            S_COMP:  state_nx = do_write ? S_WRITE : S_WB;
            S_WRITE: if (mem_ready) state_nx = S_WB;
            S_WB:    state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Phase decode for the datapath.
    always_comb begin
        accept   = (state == S_IDLE) && start;
        in_read  = (state == S_READ);
        in_comp  = (state == S_COMP);
        in_write = (state == S_WRITE);
        in_wb    = (state == S_WB);
        busy     = (state != S_IDLE);
    end

endmodule

// File: rtl/rmw_atomic_unit.sv
// Module: rmw_atomic_unit (top)
// Atomic read-modify-write sequencer on one synchronous memory port.
// Captures operands when start is accepted, reads the target under lock,
// computes, writes unless a compare-exchange misses, then reports one
// register write-back.
// Assumes: memory returns read data in the cycle mem_ready is high; in
// 32-bit mode memory updates only the low half of the addressed location.
module rmw_atomic_unit
    import amo_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 16,
    parameter int IMM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] r0_val,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              mem_lock,
    output logic              wb_src_en,
    output logic              wb_r0_en,
    output logic [DATA_W-1:0] wb_data
);

    localparam int HALF_W = DATA_W / 2;
    localparam int EXT_W  = ADDR_W - OFF_W;

    logic              dec_legal, dec_wide, dec_fetch;
    amo_op_e           dec_op;
    logic              accept, in_read, in_comp, in_write, in_wb;
    logic [DATA_W-1:0] alu_new;
    logic              alu_write;

    amo_op_e           op_q;
    logic              wide_q, fetch_q, bad_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] src_q, r0_q, old_q, new_q;

    amo_decode #(.IMM_W(IMM_W)) u_dec (
        .opcode (opcode),
        .imm    (imm),
        .legal  (dec_legal),
        .wide   (dec_wide),
        .fetch  (dec_fetch),
        .op     (dec_op)
    );

    amo_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .legal     (dec_legal),
        .mem_ready (mem_ready),
        .do_write  (alu_write),
        .accept    (accept),
        .in_read   (in_read),
        .in_comp   (in_comp),
        .in_write  (in_write),
        .in_wb     (in_wb),
        .busy      (busy)
    );

    amo_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (op_q),
        .wide     (wide_q),
        .old_val  (old_q),
        .src_val  (src_q),
        .cmp_val  (r0_q),
        .new_val  (alu_new),
        .do_write (alu_write)
    );

    // Operand capture at acceptance; address formed with sign-extended offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_ADD;
            wide_q  <= 1'b0;
            fetch_q <= 1'b0;
            bad_q   <= 1'b0;
            addr_q  <= '0;
            src_q   <= '0;
            r0_q    <= '0;
        end else if (accept) begin
            op_q    <= dec_op;
            wide_q  <= dec_wide;
            fetch_q <= dec_fetch;
            bad_q   <= !dec_legal;
            addr_q  <= base + {{EXT_W{offset[OFF_W-1]}}, offset};
            src_q   <= src_val;
            r0_q    <= r0_val;
        end
    end

    // Old value capture on the read handshake, zero-extended in 32-bit mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            old_q <= '0;
        else if (in_read && mem_ready)
            old_q <= wide_q ? mem_rdata : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
    end

    // Store value capture in the compute phase, held through the write.
    always_ff @(posedge clk) begin
        if (!rst_n)        new_q <= '0;
        else if (in_comp)  new_q <= alu_new;
    end

    // Memory port and lock drive.
    always_comb begin
        mem_req   = in_read || in_write;
        mem_we    = in_write;
        mem_wide  = wide_q;
        mem_addr  = addr_q;
        mem_wdata = new_q;
        mem_lock  = in_read || in_comp || in_write;
    end

    // Completion and register write-back drive.
    always_comb begin
        done      = in_wb;
        illegal   = in_wb && bad_q;
        wb_src_en = in_wb && !bad_q && fetch_q && (op_q != OP_CMPX);
        wb_r0_en  = in_wb && !bad_q && (op_q == OP_CMPX);
        wb_data   = old_q;
    end

endmodule

// File: rtl/rmw_atomic_unit_chk.sv
// Module: rmw_atomic_unit_chk
// Protocol checker bound to rmw_atomic_unit; observes ports only.
module rmw_atomic_unit_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              illegal,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_lock,
    input logic              wb_src_en,
    input logic              wb_r0_en
);

    // R9
    lock_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
                                     $stable(mem_addr) && $stable(mem_wdata)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_src_en || wb_r0_en) |-> (done && !illegal));

    // R7
    wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_src_en && wb_r0_en));

    // R1
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req && !$past(mem_req)));

endmodule

bind rmw_atomic_unit rmw_atomic_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .illegal   (illegal),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_lock  (mem_lock),
    .wb_src_en (wb_src_en),
    .wb_r0_en  (wb_r0_en)
);

// File: tb/sim_rmw_atomic_unit.sv
// Bench for rmw_atomic_unit: random and directed operations against a
// 16-doubleword memory model indexed by address bits 6:3.
module sim_rmw_atomic_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h0;
    logic [31:0] imm = 32'h0;
    logic [63:0] base = 64'h0;
    logic [15:0] offset = 16'h0;
    logic [63:0] src_val = 64'h0, r0_val = 64'h0;
    logic        busy, done, illegal, mem_req, mem_we, mem_wide, mem_lock;
    logic        wb_src_en, wb_r0_en;
    logic [63:0] mem_addr, mem_wdata, wb_data;
    logic [63:0] mem_rdata = 64'h0;
    logic        mem_ready = 1'b0;

    logic [63:0] mem [16];
    int          n_run = 0, n_fail = 0;
    int          rd_cnt = 0, wr_cnt = 0, lock_bad = 0;
    logic [63:0] rd_addr = 64'h0, wr_addr = 64'h0;
    logic        hold_ready = 1'b0, in_rmw = 1'b0, finished = 1'b0;

    always #2 clk = ~clk;

    rmw_atomic_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm(imm),
        .base(base), .offset(offset), .src_val(src_val), .r0_val(r0_val),
        .busy(busy), .done(done), .illegal(illegal), .mem_req(mem_req),
        .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .mem_lock(mem_lock), .wb_src_en(wb_src_en), .wb_r0_en(wb_r0_en),
        .wb_data(wb_data)
    );

    // Memory responder: random acknowledge, data from the model.
    always @(negedge clk) begin
        mem_ready <= mem_req && !hold_ready && (($urandom % 4) != 0);
        mem_rdata <= mem[mem_addr[6:3]];
    end

    // Memory update and transaction monitor.
    always @(posedge clk) begin
        if (mem_req && mem_ready && !mem_we) begin
            rd_cnt  <= rd_cnt + 1;
            rd_addr <= mem_addr;
            in_rmw  <= 1'b1;
        end
        if (mem_req && mem_ready && mem_we) begin
            wr_cnt  <= wr_cnt + 1;
            wr_addr <= mem_addr;
            in_rmw  <= 1'b0;
            mem[mem_addr[6:3]] <= mem_wide ? mem_wdata
                                           : {mem[mem_addr[6:3]][63:32], mem_wdata[31:0]};
        end
        if (done) in_rmw <= 1'b0;
        if ((mem_req && !mem_lock) || (in_rmw && !mem_lock && !done))
            lock_bad <= lock_bad + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit bench_legal(input logic [7:0] opc, input logic [31:0] im);
        bit ok_imm;
        case (im[7:0])
            8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51,
            8'hA0, 8'hA1, 8'hE1, 8'hF1: ok_imm = 1'b1;
            default: ok_imm = 1'b0;
        endcase
        return (opc == 8'hC3 || opc == 8'hDB) && ok_imm && (im[31:8] == 24'h0);
    endfunction

    function automatic logic [63:0] bench_res(input logic [31:0] im, input logic [63:0] oldm,
                                              input logic [63:0] s, input bit wide);
        logic [63:0] r;
        case (im[7:4])
            4'h0: r = oldm + s;
            4'h4: r = oldm | s;
            4'h5: r = oldm & s;
            4'hA: r = oldm ^ s;
            default: r = s;
        endcase
        return wide ? r : {32'h0, r[31:0]};
    endfunction

    // One operation; stall > 0 holds the memory off and pulses stray starts.
    task automatic run_op(input logic [7:0] opc, input logic [31:0] im,
                          input logic [63:0] b, input logic [15:0] off,
                          input logic [63:0] s, input logic [63:0] r0, input int stall);
        logic [63:0] addr, pre, oldm, res, post;
        bit          lg, wide, hit, wr, cmpx, got;
        addr = b + {{48{off[15]}}, off};
        pre  = mem[addr[6:3]];
        lg   = bench_legal(opc, im);
        wide = (opc == 8'hDB);
        oldm = wide ? pre : {32'h0, pre[31:0]};
        cmpx = (im[7:0] == 8'hF1);
        hit  = wide ? (pre == r0) : (pre[31:0] == r0[31:0]);
        wr   = lg && !(cmpx && !hit);
        res  = bench_res(im, oldm, s, wide);
        post = !wr ? pre : (wide ? res : {pre[63:32], res[31:0]});

        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; lock_bad = 0;
        opcode = opc; imm = im; base = b; offset = off; src_val = s; r0_val = r0;
        hold_ready = (stall > 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < stall; i++) begin
            opcode = 8'h00; imm = 32'hFFFF_FFFF; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        hold_ready = 1'b0;
        got = done;
        for (int i = 0; i < 200 && !got; i++) begin
            @(negedge clk);
            got = done;
        end
        chk(got, "R11 done seen", {63'h0, got}, 64'h1);
        if (!got) return;
        chk(illegal == !lg, lg ? "R2 legal accepted" : "R1 R2 illegal flagged",
            {63'h0, illegal}, {63'h0, !lg});
        chk(rd_cnt == (lg ? 1 : 0), "R1 R8 read count", rd_cnt, lg ? 1 : 0);
        chk(wr_cnt == (wr ? 1 : 0), "R8 write count", wr_cnt, wr ? 1 : 0);
        chk(mem[addr[6:3]] == post, "R4 R6 R7 memory after", mem[addr[6:3]], post);
        if (lg) chk(rd_addr == addr, "R3 address", rd_addr, addr);
        if (wr) chk(wr_addr == addr, "R3 write address", wr_addr, addr);
        chk(wb_src_en == (lg && im[0] && !cmpx), "R5 R6 src write-back",
            {63'h0, wb_src_en}, {63'h0, lg && im[0] && !cmpx});
        chk(wb_r0_en == (lg && cmpx), "R7 r0 write-back",
            {63'h0, wb_r0_en}, {63'h0, lg && cmpx});
        if (wb_src_en || wb_r0_en) chk(wb_data == oldm, "R5 R7 old value", wb_data, oldm);
        chk(lock_bad == 0, "R9 lock held", lock_bad, 0);
        @(negedge clk);
        chk(!done && !busy, "R11 single pulse, stray start dropped",
            {62'h0, done, busy}, 64'h0);
    endtask

    initial begin
        logic [31:0] ops [10] = '{32'h00, 32'h01, 32'h40, 32'h41, 32'h50,
                                  32'h51, 32'hA0, 32'hA1, 32'hE1, 32'hF1};
        void'($urandom(32'd20240607));
        for (int i = 0; i < 16; i++) mem[i] = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req && !mem_lock, "R12 reset state",
            {60'h0, busy, done, mem_req, mem_lock}, 64'h0);
        rst_n = 1'b1;

        // Directed corner cases.
        mem[2] = 64'h1234_5678_FFFF_FFFF;
        run_op(8'hC3, 32'h01, 64'h100, 16'h0010, 64'h1, 64'h0, 0);        // R4 32-bit wrap
        run_op(8'hDB, 32'h00, 64'h200, 16'hFFF8, 64'h5, 64'h0, 0);        // R3 negative offset
        run_op(8'hDB, 32'hE1, 64'h8, 16'h0, 64'hDEAD_BEEF_0000_0001, 64'h0, 0); // R6
        mem[3] = 64'hAAAA_0000_5555_0001;
        run_op(8'hC3, 32'hF1, 64'h18, 16'h0, 64'h77, 64'hFFFF_0000_5555_0001, 0); // R7 low-half hit
        run_op(8'hDB, 32'hF1, 64'h18, 16'h0, 64'h99, 64'h1, 0);           // R8 miss
        run_op(8'hCB, 32'h00, 64'h0, 16'h0, 64'h1, 64'h0, 0);             // R1 half-word
        run_op(8'hD3, 32'h00, 64'h0, 16'h0, 64'h1, 64'h0, 0);             // R1 byte
        run_op(8'hDB, 32'hE0, 64'h0, 16'h0, 64'h1, 64'h0, 0);             // R2 xchg w/o fetch
        run_op(8'hDB, 32'h100, 64'h0, 16'h0, 64'h1, 64'h0, 0);            // R2 upper bits
        run_op(8'hDB, 32'h41, 64'h30, 16'h0, 64'hF0, 64'h0, 4);           // R10 R11 stall

        // Constrained random.
        for (int n = 0; n < 150; n++) begin
            logic [7:0]  opc;
            logic [31:0] im;
            logic [63:0] b, s, r0, tgt;
            logic [15:0] off;
            int sel;
            sel = $urandom % 20;
            opc = (sel == 0) ? 8'hCB : (sel == 1) ? 8'hD3 : (sel < 11) ? 8'hC3 : 8'hDB;
            im  = ops[$urandom % 10];
            if (($urandom % 16) == 0) im = $urandom % 256;
            b   = {$urandom, $urandom};
            off = $urandom;
            s   = {$urandom, $urandom};
            tgt = mem[(b[6:3] + off[6:3]) & 4'hF];
            tgt = mem[(b + {{48{off[15]}}, off}) >> 3 & 64'hF];
            r0  = ($urandom % 2) ? {$urandom, tgt[31:0]} : {$urandom, $urandom};
            if (($urandom % 4) == 0 && opc == 8'hDB) r0 = tgt;
            run_op(opc, im, b, off, s, r0, 0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule